// File: doc/BRIEF.md
# Transmit Burst Event Sequencer

This block produces the timed control events for a single burst of a slotted TDMA radio transmitter. Software first loads a small event table in which each entry pairs a 4-bit event code with a delay in ticks. It also writes a header that holds an initial delay and an initial level for the transmitter enable. A rising edge on the slot clock starts a burst. The sequencer waits out the initial delay, then walks the table. Each entry's delay is counted from the event before it. When an entry's delay expires, its event fires.

Events drive a transmitter-enable level, a sensing-window level, and single-cycle strobes for ramp up, ramp down, sensing-window start and end, and modulation start and end. A tick lasts 1/24000 s, which is 2.5 modulated bits. The tick is derived from the system clock by a parameterised divider.

The modulation-end entry does not count from the slot edge. It waits for a last-bit-done pulse from the modulator, then adds a fixed 30-tick filter-flush delay to its own programmed delay. Every entry after it is timed from that point, so bursts of any length power down correctly.

Top module: `tx_event_sequencer`

## Requirements
- R1: Delays count ticks of CLK_PER_TICK clock cycles. An entry with delay D fires N*D+1 clock cycles after the previous event fires, where N is CLK_PER_TICK.
- R2: When the sequencer is idle and the header has been written, a slot-clock rising edge does three things at the clock edge that samples it. It raises busy. It loads txEnable with the header level. It starts the initial delay I. The first entry (delay D0) then fires N*(I+D0)+2 cycles after that edge.
- R3: Event codes map to outputs as follows:
  - 0x1: sensing-window start strobe.
  - 0x2: sensing-window end strobe.
  - 0x4: ramp-up strobe.
  - 0x5: modulation-start strobe.
  - 0x6: modulation-end strobe.
  - 0x7: ramp-down strobe.
  - 0x0, 0x9 and 0xA to 0xF: no output change.
- R4: senseWindow goes high with the 0x1 strobe and low with the 0x2 strobe. It is forced low when a burst ends.
- R5: Code 0x3 sets txEnable high and code 0x8 sets it low. txEnable keeps its value after the burst ends.
- R6: On reaching a 0x6 entry with delay D, the sequencer waits for lastBitDone. The modulation-end strobe then fires (30+D)*N+1 cycles after the clock edge that samples lastBitDone. Later entries are timed from that strobe. A lastBitDone pulse at any other time has no effect.
- R7: An entry with code 0x0 and delay 0 ends the list. The list also ends after the 16th entry. busy drops in the cycle the last event fires.
- R8: Slot-clock edges that arrive while busy is high are ignored, and the burst timing is unchanged.
- R9: A slot-clock edge that arrives before any header write produces a one-cycle cfgError pulse and starts no burst.
- R10: Table and header contents persist across bursts. A table write stores code and delay at the given index.
- R11: At most one strobe is active in any cycle. No strobe or txEnable change occurs while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotClk | input | 1 | Slot clock; a rising edge starts a burst |
| tblWrEn | input | 1 | Table entry write enable |
| tblWrAddr | input | ADDR_W | Table entry index |
| tblWrCode | input | 4 | Event code to store |
| tblWrDelay | input | DELAY_W | Delay in ticks to store |
| hdrWrEn | input | 1 | Header write enable; marks the table as ready |
| hdrDelay | input | DELAY_W | Initial delay in ticks |
| hdrLevel | input | 1 | Initial txEnable level |
| lastBitDone | input | 1 | Pulse from the modulator when the final bit has been sent |
| txEnable | output | 1 | Transmitter enable level |
| senseWindow | output | 1 | Carrier-sensing window level |
| senseStartStb | output | 1 | Sensing-window start strobe |
| senseEndStb | output | 1 | Sensing-window end strobe |
| rampUpStb | output | 1 | Ramp-up strobe |
| rampDownStb | output | 1 | Ramp-down strobe |
| modStartStb | output | 1 | Modulation-start strobe |
| modEndStb | output | 1 | Modulation-end strobe |
| busy | output | 1 | Burst in progress |
| cfgError | output | 1 | Slot edge arrived with no header loaded |

## Verification
A wrong table index or remaining-tick count shows up at the next strobe. That strobe carries the wrong code or arrives a multiple of N cycles away from its expected cycle, so the fault is visible within one entry's delay. A modulation-end wait that is mis-anchored moves every later power-down strobe by the same offset, and this is visible 30 ticks after lastBitDone. A stuck state, such as missing the end of the list or leaving MODWAIT early, appears as busy staying high, as extra strobes while idle, or as senseWindow left asserted after the burst.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] EV_NOP       = 4'h0;
  localparam logic [CODE_W-1:0] EV_SENSE_ON  = 4'h1;
  localparam logic [CODE_W-1:0] EV_SENSE_OFF = 4'h2;
  localparam logic [CODE_W-1:0] EV_TX_ON     = 4'h3;
  localparam logic [CODE_W-1:0] EV_RAMP_UP   = 4'h4;
  localparam logic [CODE_W-1:0] EV_MOD_START = 4'h5;
  localparam logic [CODE_W-1:0] EV_MOD_END   = 4'h6;
  localparam logic [CODE_W-1:0] EV_RAMP_DOWN = 4'h7;
  localparam logic [CODE_W-1:0] EV_TX_OFF    = 4'h8;

  // strobe vector bit positions
  localparam int STB_SENSE_ON  = 0;
  localparam int STB_SENSE_OFF = 1;
  localparam int STB_RAMP_UP   = 2;
  localparam int STB_RAMP_DOWN = 3;
  localparam int STB_MOD_START = 4;
  localparam int STB_MOD_END   = 5;
  localparam int STB_W         = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_MODWAIT
  } seqState_e;

  typedef struct packed {
    logic startBurst;
    logic fetch;
    logic flushLoad;
    logic countEn;
  } seqCtl_t;
endpackage

// File: rtl/txseq_datapath.sv
module txseq_datapath
  import txseq_pkg::*;
#(
  parameter int CLK_PER_TICK = 1000,
  parameter int ENTRIES      = 16,
  parameter int DELAY_W      = 16,
  parameter int FLUSH_TICKS  = 30,
  localparam int ADDR_W      = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCtl_t            ctl,
  input  logic               tblWrEn,
  input  logic [ADDR_W-1:0]  tblWrAddr,
  input  logic [CODE_W-1:0]  tblWrCode,
  input  logic [DELAY_W-1:0] tblWrDelay,
  input  logic               hdrWrEn,
  input  logic [DELAY_W-1:0] hdrDelay,
  input  logic               hdrLevel,
  output logic               remZero,
  output logic [CODE_W-1:0]  entryCode,
  output logic               entryEnd,
  output logic               tableReady,
  output logic               initLevel
);
  localparam int IDX_W = ADDR_W + 1;
  localparam int REM_W = DELAY_W + 1;
  localparam int PRE_W = $clog2(CLK_PER_TICK + 1);

  logic [CODE_W-1:0]  codeMem  [ENTRIES];
  logic [DELAY_W-1:0] delayMem [ENTRIES];
  logic [IDX_W-1:0]   idx;
  logic [REM_W-1:0]   remTicks;
  logic [DELAY_W-1:0] entryDelay;
  logic [DELAY_W-1:0] initDelay;
  logic               restart;
  logic               tick;

  // table storage, write port
  always_ff @(posedge clk) begin
    if (tblWrEn) begin
      codeMem[tblWrAddr]  <= tblWrCode;
      delayMem[tblWrAddr] <= tblWrDelay;
    end
  end

  assign entryCode  = codeMem[idx[ADDR_W-1:0]];
  assign entryDelay = delayMem[idx[ADDR_W-1:0]];
  assign entryEnd   = (idx == IDX_W'(ENTRIES)) ||
                      (entryCode == EV_NOP && entryDelay == '0);

  // header
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initDelay  <= '0;
      initLevel  <= 1'b0;
      tableReady <= 1'b0;
    end else if (hdrWrEn) begin
      initDelay  <= hdrDelay;
      initLevel  <= hdrLevel;
      tableReady <= 1'b1;
    end
  end

  assign restart = ctl.startBurst | ctl.fetch | ctl.flushLoad;

  // tick prescaler, restarted whenever a new delay is loaded
  generate
    if (CLK_PER_TICK <= 1) begin : g_noDiv
      assign tick = 1'b1;
    end else begin : g_div
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          preCnt <= '0;
        else if (restart)                   preCnt <= '0;
        else if (preCnt == PRE_W'(CLK_PER_TICK - 1)) preCnt <= '0;
        else                                preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PRE_W'(CLK_PER_TICK - 1));
    end
  endgenerate

  // remaining-tick counter and table index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remTicks <= '0;
      idx      <= '0;
    end else if (ctl.startBurst) begin
      remTicks <= {1'b0, initDelay};
      idx      <= '0;
    end else if (ctl.fetch) begin
      remTicks <= {1'b0, entryDelay};
      idx      <= idx + 1'b1;
    end else if (ctl.flushLoad) begin
      remTicks <= remTicks + REM_W'(FLUSH_TICKS);
    end else if (ctl.countEn && remTicks != '0 && tick) begin
      remTicks <= remTicks - 1'b1;
    end
  end

  assign remZero = (remTicks == '0);

  // R1
  rem_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countEn && !restart) |=> (remTicks <= $past(remTicks)));

  // R6
  flush_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flushLoad |=> (remTicks >= REM_W'(FLUSH_TICKS)));

  // R7
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    idx <= IDX_W'(ENTRIES));
endmodule

// File: rtl/txseq_control.sv
module txseq_control
  import txseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotClk,
  input  logic              lastBitDone,
  input  logic              remZero,
  input  logic [CODE_W-1:0] entryCode,
  input  logic              entryEnd,
  input  logic              tableReady,
  input  logic              initLevel,
  output seqCtl_t           ctl,
  output logic              txEnable,
  output logic              senseWindow,
  output logic [STB_W-1:0]  stbQ,
  output logic              busy,
  output logic              cfgError
);
  seqState_e         state;
  logic              slotPrev;
  logic              slotRise;
  logic              pendValid;
  logic [CODE_W-1:0] pendCode;

  assign slotRise = slotClk & ~slotPrev;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    ctl = '0;
    case (state)
      ST_IDLE:    ctl.startBurst = slotRise && tableReady;
      ST_DELAY: begin
        ctl.countEn = !remZero;
        ctl.fetch   = remZero && !entryEnd;
      end
      ST_MODWAIT: ctl.flushLoad = lastBitDone;
      default:    ctl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      slotPrev    <= 1'b0;
      pendValid   <= 1'b0;
      pendCode    <= EV_NOP;
      txEnable    <= 1'b0;
      senseWindow <= 1'b0;
      stbQ        <= '0;
      cfgError    <= 1'b0;
    end else begin
      slotPrev <= slotClk;
      stbQ     <= '0;
      cfgError <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (slotRise) begin
            if (tableReady) begin
              state     <= ST_DELAY;
              pendValid <= 1'b0;
              txEnable  <= initLevel;
            end else begin
              cfgError <= 1'b1;
            end
          end
        end
        ST_DELAY: begin
          if (remZero) begin
            if (pendValid) begin
              case (pendCode)
                EV_SENSE_ON:  begin stbQ[STB_SENSE_ON]  <= 1'b1; senseWindow <= 1'b1; end
                EV_SENSE_OFF: begin stbQ[STB_SENSE_OFF] <= 1'b1; senseWindow <= 1'b0; end
                EV_TX_ON:     txEnable <= 1'b1;
                EV_RAMP_UP:   stbQ[STB_RAMP_UP]   <= 1'b1;
                EV_MOD_START: stbQ[STB_MOD_START] <= 1'b1;
                EV_MOD_END:   stbQ[STB_MOD_END]   <= 1'b1;
                EV_RAMP_DOWN: stbQ[STB_RAMP_DOWN] <= 1'b1;
                EV_TX_OFF:    txEnable <= 1'b0;
                default:      ;
              endcase
            end
            if (entryEnd) begin
              state       <= ST_IDLE;
              pendValid   <= 1'b0;
              senseWindow <= 1'b0;
            end else if (entryCode == EV_MOD_END) begin
              state     <= ST_MODWAIT;
              pendValid <= 1'b0;
            end else begin
              pendCode  <= entryCode;
              pendValid <= 1'b1;
            end
          end
        end
        ST_MODWAIT: begin
          if (lastBitDone) begin
            state     <= ST_DELAY;
            pendCode  <= EV_MOD_END;
            pendValid <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbQ));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stbQ != '0) |-> $past(busy));

  // R2
  start_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (txEnable == $past(initLevel)));

  // R9
  cfg_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (!busy && !tableReady));

  // R6
  modwait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MODWAIT && !lastBitDone) |=> (stbQ == '0 && busy));
endmodule

// File: rtl/tx_event_sequencer.sv
module tx_event_sequencer
  import txseq_pkg::*;
#(
  parameter int CLK_PER_TICK = 1000,
  parameter int ENTRIES      = 16,
  parameter int DELAY_W      = 16,
  parameter int FLUSH_TICKS  = 30,
  localparam int ADDR_W      = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               slotClk,
  input  logic               tblWrEn,
  input  logic [ADDR_W-1:0]  tblWrAddr,
  input  logic [3:0]         tblWrCode,
  input  logic [DELAY_W-1:0] tblWrDelay,
  input  logic               hdrWrEn,
  input  logic [DELAY_W-1:0] hdrDelay,
  input  logic               hdrLevel,
  input  logic               lastBitDone,
  output logic               txEnable,
  output logic               senseWindow,
  output logic               senseStartStb,
  output logic               senseEndStb,
  output logic               rampUpStb,
  output logic               rampDownStb,
  output logic               modStartStb,
  output logic               modEndStb,
  output logic               busy,
  output logic               cfgError
);
  seqCtl_t           ctl;
  logic              remZero;
  logic [CODE_W-1:0] entryCode;
  logic              entryEnd;
  logic              tableReady;
  logic              initLevel;
  logic [STB_W-1:0]  stbQ;

  txseq_datapath #(
    .CLK_PER_TICK(CLK_PER_TICK),
    .ENTRIES     (ENTRIES),
    .DELAY_W     (DELAY_W),
    .FLUSH_TICKS (FLUSH_TICKS)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .tblWrEn    (tblWrEn),
    .tblWrAddr  (tblWrAddr),
    .tblWrCode  (tblWrCode),
    .tblWrDelay (tblWrDelay),
    .hdrWrEn    (hdrWrEn),
    .hdrDelay   (hdrDelay),
    .hdrLevel   (hdrLevel),
    .remZero    (remZero),
    .entryCode  (entryCode),
    .entryEnd   (entryEnd),
    .tableReady (tableReady),
    .initLevel  (initLevel)
  );

  txseq_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .slotClk     (slotClk),
    .lastBitDone (lastBitDone),
    .remZero     (remZero),
    .entryCode   (entryCode),
    .entryEnd    (entryEnd),
    .tableReady  (tableReady),
    .initLevel   (initLevel),
    .ctl         (ctl),
    .txEnable    (txEnable),
    .senseWindow (senseWindow),
    .stbQ        (stbQ),
    .busy        (busy),
    .cfgError    (cfgError)
  );

  assign senseStartStb = stbQ[STB_SENSE_ON];
  assign senseEndStb   = stbQ[STB_SENSE_OFF];
  assign rampUpStb     = stbQ[STB_RAMP_UP];
  assign rampDownStb   = stbQ[STB_RAMP_DOWN];
  assign modStartStb   = stbQ[STB_MOD_START];
  assign modEndStb     = stbQ[STB_MOD_END];
endmodule

// File: tb/test_tx_event_sequencer.sv
module test_tx_event_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int FLUSH      = 30;

  typedef struct {
    int     code;
    longint t;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slotClk = 1'b0;
  logic        tblWrEn = 1'b0;
  logic [3:0]  tblWrAddr = '0;
  logic [3:0]  tblWrCode = '0;
  logic [15:0] tblWrDelay = '0;
  logic        hdrWrEn = 1'b0;
  logic [15:0] hdrDelay = '0;
  logic        hdrLevel = 1'b0;
  logic        lastBitDone = 1'b0;
  logic txEnable, senseWindow, senseStartStb, senseEndStb;
  logic rampUpStb, rampDownStb, modStartStb, modEndStb, busy, cfgError;

  int       checks = 0;
  int       failures = 0;
  longint   cyc = 0;
  bit       monOn = 1'b0;
  bit       finished = 1'b0;
  expItem_t expQ[$];
  int       tbCode[16];
  int       tbDelay[16];
  int       hdrI;
  bit       hdrL;
  bit       lvl = 1'b0;

  tx_event_sequencer #(.CLK_PER_TICK(N)) i_tx_event_sequencer (
    .clk(clk), .rstN(rstN), .slotClk(slotClk),
    .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr), .tblWrCode(tblWrCode),
    .tblWrDelay(tblWrDelay), .hdrWrEn(hdrWrEn), .hdrDelay(hdrDelay),
    .hdrLevel(hdrLevel), .lastBitDone(lastBitDone),
    .txEnable(txEnable), .senseWindow(senseWindow),
    .senseStartStb(senseStartStb), .senseEndStb(senseEndStb),
    .rampUpStb(rampUpStb), .rampDownStb(rampDownStb),
    .modStartStb(modStartStb), .modEndStb(modEndStb),
    .busy(busy), .cfgError(cfgError)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic string reqOf(input int code);
    case (code)
      1, 2:    return "R4";
      3, 8:    return "R5";
      6:       return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // scoreboard monitor
  bit prevBusy = 1'b0;
  bit prevTx = 1'b0;
  always @(negedge clk) begin
    int obs[$];
    bit busyRose;
    expItem_t e;
    if (monOn) begin
      obs.delete();
      busyRose = busy && !prevBusy;
      if (senseStartStb) obs.push_back(1);
      if (senseEndStb)   obs.push_back(2);
      if (rampUpStb)     obs.push_back(4);
      if (modStartStb)   obs.push_back(5);
      if (modEndStb)     obs.push_back(6);
      if (rampDownStb)   obs.push_back(7);
      if (txEnable != prevTx && !busyRose) obs.push_back(txEnable ? 3 : 8);
      if (obs.size() > 1) check(1'b0, "R11 multiple events", obs.size(), 1);
      foreach (obs[k]) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R11 unexpected event code", obs[k], 0);
        end else begin
          e = expQ.pop_front();
          check(obs[k] == e.code, {reqOf(e.code), " event code"}, obs[k], e.code);
          check(cyc == e.t, {reqOf(e.code), "/R1 event time"}, cyc, e.t);
        end
        if (obs[k] == 1) check(senseWindow == 1'b1, "R4 window high at start", senseWindow, 1);
        if (obs[k] == 2) check(senseWindow == 1'b0, "R4 window low at end", senseWindow, 0);
      end
      prevBusy = busy;
      prevTx   = txEnable;
    end
  end

  task automatic writeEntry(input int a, input int c, input int d);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrAddr = 4'(a); tblWrCode = 4'(c); tblWrDelay = 16'(d);
    tbCode[a] = c; tbDelay[a] = d;
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic writeHeader(input int d, input bit l);
    @(negedge clk);
    hdrWrEn = 1'b1; hdrDelay = 16'(d); hdrLevel = l;
    hdrI = d; hdrL = l;
    @(negedge clk);
    hdrWrEn = 1'b0;
  endtask

  task automatic pushEv(input int code, input longint t);
    expItem_t e;
    bit vis;
    vis = 1'b1;
    if (code == 3) begin vis = (lvl == 1'b0); lvl = 1'b1; end
    else if (code == 8) begin vis = (lvl == 1'b1); lvl = 1'b0; end
    else if (code == 0 || code >= 9) vis = 1'b0;
    if (vis) begin
      e.code = code; e.t = t;
      expQ.push_back(e);
    end
  endtask

  task automatic waitIdle();
    for (int w = 0; w < 20000 && busy; w++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic runBurst(input int late, input bit spurious, input bit extraSlot);
    longint rec;
    longint t;
    int     modIdx;
    int     i;
    modIdx = -1;
    @(negedge clk);
    slotClk = 1'b1;
    rec = cyc;
    lvl = hdrL;
    t = rec + N * hdrI + 2;
    for (i = 0; i < 16; i++) begin
      if (tbCode[i] == 0 && tbDelay[i] == 0) break;
      if (tbCode[i] == 6) begin modIdx = i; break; end
      t = t + N * tbDelay[i] + 1;
      pushEv(tbCode[i], t);
    end
    @(negedge clk);
    slotClk = 1'b0;
    check(busy == 1'b1, "R2 busy after slot edge", busy, 1);
    check(txEnable == hdrL, "R2 initial enable level", txEnable, hdrL);
    if (spurious) begin
      // R6: early pulse while not waiting must be ignored
      lastBitDone = 1'b1;
      @(negedge clk);
      lastBitDone = 1'b0;
    end
    if (extraSlot) begin
      repeat (3) @(negedge clk);
      slotClk = 1'b1;
      @(negedge clk);
      slotClk = 1'b0;
      check(busy == 1'b1, "R8 edge ignored while busy", busy, 1);
    end
    if (modIdx >= 0) begin
      for (int w = 0; w < 20000 && expQ.size() > 0; w++) @(negedge clk);
      repeat (late) @(negedge clk);
      check(busy == 1'b1, "R6 waiting for last bit", busy, 1);
      lastBitDone = 1'b1;
      rec = cyc;
      t = rec + N * (tbDelay[modIdx] + FLUSH) + 2;
      pushEv(6, t);
      for (i = modIdx + 1; i < 16; i++) begin
        if (tbCode[i] == 0 && tbDelay[i] == 0) break;
        t = t + N * tbDelay[i] + 1;
        pushEv(tbCode[i], t);
      end
      @(negedge clk);
      lastBitDone = 1'b0;
    end
    waitIdle();
    check(busy == 1'b0, "R7 busy drops at list end", busy, 0);
    check(senseWindow == 1'b0, "R4 window low after burst", senseWindow, 0);
    check(expQ.size() == 0, "R3 all expected events seen", expQ.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R11 reset busy", busy, 0);
    check(txEnable == 1'b0, "R5 reset txEnable", txEnable, 0);
    check(senseWindow == 1'b0, "R4 reset window", senseWindow, 0);
    check(cfgError == 1'b0, "R9 reset error", cfgError, 0);
    check({senseStartStb, senseEndStb, rampUpStb, rampDownStb, modStartStb, modEndStb} == 6'b0,
          "R11 reset strobes", 0, 0);
    prevBusy = busy; prevTx = txEnable;
    monOn = 1'b1;

    // R9: slot edge before header
    @(negedge clk);
    slotClk = 1'b1;
    @(negedge clk);
    slotClk = 1'b0;
    check(cfgError == 1'b1, "R9 error pulse", cfgError, 1);
    check(busy == 1'b0, "R9 no burst started", busy, 0);
    @(negedge clk);
    check(cfgError == 1'b0, "R9 error is one cycle", cfgError, 0);

    // table A (R10 writes)
    writeEntry(0, 1, 2);
    writeEntry(1, 2, 3);
    writeEntry(2, 3, 1);
    writeEntry(3, 4, 2);
    writeEntry(4, 12, 1);   // unknown code: no output (R3)
    writeEntry(5, 5, 2);
    writeEntry(6, 6, 1);
    writeEntry(7, 7, 2);
    writeEntry(8, 8, 1);
    writeEntry(9, 9, 1);
    writeEntry(10, 0, 0);   // terminator (R7)
    writeHeader(3, 1'b0);
    runBurst(7, 1'b0, 1'b1);

    // R10: same table, new header, longer burst, spurious last-bit pulse
    writeHeader(5, 1'b1);
    runBurst(40, 1'b1, 1'b0);
    check(txEnable == 1'b0, "R5 level held after burst", txEnable, 0);

    // R7: full table without terminator
    for (int a = 0; a < 16; a++) writeEntry(a, 4, 1);
    writeHeader(2, 1'b0);
    runBurst(0, 1'b0, 1'b0);

    // R11: quiet while idle
    repeat (50) @(negedge clk);
    check(expQ.size() == 0, "R11 idle quiet", expQ.size(), 0);
    finishRun();
  end
endmodule